// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit I/O virtual address into a physical address by fetching one entry from a first-level table and then one entry from a second-level table in memory. It splits the address 10/10/12. The top ten bits select a first-level slot. The next ten bits select a second-level slot. The low twelve bits are the offset inside a 4 KiB page. Every table entry is a bare page frame number, and a table or page starts at its frame number times 4096.

A requester hands over an address on a valid/ready request channel. The walker issues its two reads on a simple read master: an address with valid/ready, and 32-bit data returned with a data-valid strobe. It then presents either the physical address or a translation fault on a valid/ready response channel. Mapping uses no valid bit. An unused first-level slot points at a shared dummy second-level table, and an unused second-level slot points at a shared dummy page. Both marker frame numbers are configuration inputs, and a walk that meets either marker ends in a fault. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is 1 only while no walk is in progress and no response is pending. `rsp_valid` and `req_ready` are never 1 in the same cycle, so a request offered in the cycle its predecessor's response is taken waits at least one cycle.
- R2: The first read goes to address `cfg_root_pfn * 4096 + va[31:22] * 4`.
- R3: The second read goes to address `F1 * 4096 + va[21:12] * 4`. F1 is bits 26:0 of the first-level entry, and entry bits 31:27 are ignored.
- R4: If bits 26:0 of the first-level entry equal `cfg_dummy_tbl`, the walk ends with `rsp_fault` = 1 and no second read is issued.
- R5: If bits 26:0 of the second-level entry equal `cfg_dummy_page`, the walk ends with `rsp_fault` = 1.
- R6: Otherwise the response carries `rsp_fault` = 0 and `rsp_pa` = {second-level entry bits 26:0, va[11:0]}, which is 39 bits.
- R7: On a fault, `rsp_pa` is all zeros.
- R8: While `rsp_valid` = 1 and `rsp_ready` = 0, `rsp_valid`, `rsp_pa` and `rsp_fault` hold their values.
- R9: While `mem_valid` = 1 and `mem_ready` = 0, `mem_valid` and `mem_addr` hold. `mem_addr` is always 4-byte aligned. Exactly one read is issued per level visited.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_root_pfn | input | 27 | Frame number of the first-level table |
| cfg_dummy_tbl | input | 27 | Frame number that marks an unused first-level slot |
| cfg_dummy_page | input | 27 | Frame number that marks an unused second-level slot |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 39 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation fault |
| mem_valid | output | 1 | Read request to memory |
| mem_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 39 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned table entry |

## Verification
Two events can land in the same cycle: the requester takes a response, and the next request is already offered. The bench raises `req_valid` in the very cycle it raises `rsp_ready`. It judges the outcome at the ports: `req_ready` must be 0 in that cycle and 1 in the following one, and the new walk must still produce its own correct reads and result. The read port is also stalled through a repeating `mem_ready` pattern, and data return is delayed by varying amounts. Under these conditions the issued addresses and the number of reads are compared with values the bench computes from the table layout. This covers both fault markers, including entries whose unused upper bits are set.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_L2_REQ,
        S_L2_WAIT,
        S_RESP
    } walk_state_e;

endpackage

// File: rtl/va_fields.sv
module va_fields #(
    parameter int IDX_W = 10,
    parameter int OFS_W = 12,
    localparam int VA_W = 2 * IDX_W + OFS_W
) (
    input  logic [VA_W-1:0]  va,
    output logic [IDX_W-1:0] idx_hi,
    output logic [IDX_W-1:0] idx_lo,
    output logic [OFS_W-1:0] offset
);
    assign idx_hi = va[VA_W-1 -: IDX_W];
    assign idx_lo = va[OFS_W +: IDX_W];
    assign offset = va[OFS_W-1:0];
endmodule

// File: rtl/pte_addr.sv
module pte_addr #(
    parameter int PFN_W = 27,
    parameter int IDX_W = 10,
    parameter int OFS_W = 12,
    localparam int ADDR_W = PFN_W + OFS_W,
    localparam int PAD_W  = OFS_W - IDX_W - 2
) (
    input  logic [PFN_W-1:0]  table_pfn,
    input  logic [IDX_W-1:0]  slot,
    output logic [ADDR_W-1:0] addr
);
    // Entry address: frame * page size + slot * 4 bytes.
    generate
        if (PAD_W > 0) begin : g_pad
            assign addr = {table_pfn, {PAD_W{1'b0}}, slot, 2'b00};
        end else begin : g_nopad
            assign addr = {table_pfn, slot, 2'b00};
        end
    endgenerate
endmodule

// File: rtl/frame_check.sv
module frame_check #(
    parameter int ENTRY_W = 32,
    parameter int PFN_W   = 27
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [PFN_W-1:0]   marker,
    output logic [PFN_W-1:0]   pfn,
    output logic               is_marker
);
    assign pfn       = entry[PFN_W-1:0];
    assign is_marker = (entry[PFN_W-1:0] == marker);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int OFS_W   = 12,
    parameter int PFN_W   = 27,
    parameter int ENTRY_W = 32,
    localparam int VA_W   = 2 * IDX_W + OFS_W,
    localparam int ADDR_W = PFN_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PFN_W-1:0]   cfg_root_pfn,
    input  logic [PFN_W-1:0]   cfg_dummy_tbl,
    input  logic [PFN_W-1:0]   cfg_dummy_page,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [ADDR_W-1:0]  rsp_pa,
    output logic               rsp_fault,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata
);

    typedef struct packed {
        walk_state_e       state;
        logic [VA_W-1:0]   va;
        logic [PFN_W-1:0]  l2_pfn;
        logic [ADDR_W-1:0] pa;
        logic              fault;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [IDX_W-1:0] idx_hi, idx_lo;
    logic [OFS_W-1:0] page_ofs;
    logic [PFN_W-1:0] tbl_pfn_sel, marker_sel, entry_pfn;
    logic [IDX_W-1:0] slot_sel;
    logic             level2, entry_is_marker;

    va_fields #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_fields (
        .va     (r_q.va),
        .idx_hi (idx_hi),
        .idx_lo (idx_lo),
        .offset (page_ofs)
    );

    assign level2      = (r_q.state == S_L2_REQ) || (r_q.state == S_L2_WAIT);
    assign tbl_pfn_sel = level2 ? r_q.l2_pfn : cfg_root_pfn;
    assign slot_sel    = level2 ? idx_lo : idx_hi;
    assign marker_sel  = level2 ? cfg_dummy_page : cfg_dummy_tbl;

    pte_addr #(.PFN_W(PFN_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_addr (
        .table_pfn (tbl_pfn_sel),
        .slot      (slot_sel),
        .addr      (mem_addr)
    );

    frame_check #(.ENTRY_W(ENTRY_W), .PFN_W(PFN_W)) u_check (
        .entry     (mem_rdata),
        .marker    (marker_sel),
        .pfn       (entry_pfn),
        .is_marker (entry_is_marker)
    );

    assign req_ready = (r_q.state == S_IDLE);
    assign rsp_valid = (r_q.state == S_RESP);
    assign mem_valid = (r_q.state == S_L1_REQ) || (r_q.state == S_L2_REQ);
    assign rsp_pa    = r_q.pa;
    assign rsp_fault = r_q.fault;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.va    = req_va;
                    r_d.state = S_L1_REQ;
                end
            end
            S_L1_REQ: begin
                if (mem_ready) r_d.state = S_L1_WAIT;
            end
            S_L1_WAIT: begin
                if (mem_rvalid) begin
                    if (entry_is_marker) begin
                        r_d.fault = 1'b1;
                        r_d.pa    = '0;
                        r_d.state = S_RESP;
                    end else begin
                        r_d.l2_pfn = entry_pfn;
                        r_d.state  = S_L2_REQ;
                    end
                end
            end
            S_L2_REQ: begin
                if (mem_ready) r_d.state = S_L2_WAIT;
            end
            S_L2_WAIT: begin
                if (mem_rvalid) begin
                    r_d.fault = entry_is_marker;
                    r_d.pa    = entry_is_marker ? '0 : {entry_pfn, page_ofs};
                    r_d.state = S_RESP;
                end
            end
            S_RESP: begin
                if (rsp_ready) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, va: '0, l2_pfn: '0, pa: '0, fault: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // R1: a pending response blocks new requests
    a_r1_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R1: an accepted request keeps the walker busy in the next cycle
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: fault responses carry a zero address
    a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

    // R8: response stable until taken
    a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

    // R9: read request stable until accepted
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    // R9: entry reads are word aligned
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R9: no new read is issued in the cycle after one is accepted
    a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> !mem_valid);

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    localparam int PFN_W  = 27;
    localparam int ADDR_W = 39;
    localparam logic [PFN_W-1:0] ROOT  = 27'h100;
    localparam logic [PFN_W-1:0] DTBL  = 27'h1234;
    localparam logic [PFN_W-1:0] DPAGE = 27'h5678;
    localparam int L2_BASE = 32'h2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b0, rsp_fault;
    logic [31:0] req_va = '0;
    logic [ADDR_W-1:0] rsp_pa, mem_addr;
    logic mem_valid, mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc_total = 0;
    logic [ADDR_W-1:0] acc_prev = '0, acc_last = '0;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .cfg_root_pfn(ROOT), .cfg_dummy_tbl(DTBL), .cfg_dummy_page(DPAGE),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Table contents, computed arithmetically. Upper entry bits are junk on purpose.
    function automatic logic [31:0] l1_entry(int i);
        logic [31:0] junk = (i % 2 == 1) ? 32'hF800_0000 : 32'h0;
        if (i % 5 == 2) return junk | 32'(DTBL);
        return junk | 32'(L2_BASE + i);
    endfunction

    function automatic logic [31:0] l2_entry(int i, int j);
        logic [31:0] junk = (j % 3 == 0) ? 32'h8000_0000 : 32'h0;
        if ((i + j) % 7 == 3) return junk | 32'(DPAGE);
        return junk | 32'(32'h40000 + i * 1024 + j);
    endfunction

    function automatic logic [31:0] mem_model(logic [ADDR_W-1:0] a);
        int frame = int'(a >> 12);
        int slot  = int'((a >> 2) & 39'h3FF);
        if (frame == int'(ROOT)) return l1_entry(slot);
        if (frame >= L2_BASE && frame < L2_BASE + 1024) return l2_entry(frame - L2_BASE, slot);
        return 32'hDEAD_BEEF;
    endfunction

    // Memory: stalls on a repeating ready pattern, returns data after a variable gap.
    logic pend = 1'b0;
    logic [ADDR_W-1:0] pend_addr = '0;
    int gap = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rvalid <= 1'b0;
        mem_ready  <= (cyc % 4) != 1;
        if (mem_valid && mem_ready && !pend) begin
            pend      <= 1'b1;
            pend_addr <= mem_addr;
            gap       <= cyc % 3;
            acc_total <= acc_total + 1;
            acc_prev  <= acc_last;
            acc_last  <= mem_addr;
        end else if (pend) begin
            if (gap == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_model(pend_addr);
                pend       <= 1'b0;
            end else begin
                gap <= gap - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One walk; hold = cycles the response is left untaken; collide = offer next request while taking it.
    task automatic walk(input int i, input int j, input int ofs, input int hold, input bit collide);
        logic [31:0] va = (32'(i) << 22) | (32'(j) << 12) | 32'(ofs);
        logic [ADDR_W-1:0] a1 = {ROOT, 12'(i * 4)};
        logic [PFN_W-1:0] f1 = l1_entry(i)[PFN_W-1:0];
        logic [PFN_W-1:0] f2 = l2_entry(i, j)[PFN_W-1:0];
        logic [ADDR_W-1:0] a2 = {f1, 12'(j * 4)};
        bit flt1 = (f1 == DTBL);
        bit flt2 = !flt1 && (f2 == DPAGE);
        logic [ADDR_W-1:0] exp_pa = (flt1 || flt2) ? '0 : {f2, 12'(ofs)};
        int n0 = acc_total;
        logic [ADDR_W-1:0] pa_seen;
        logic flt_seen;
        req_va = va;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        pa_seen = rsp_pa;
        flt_seen = rsp_fault;
        check(flt_seen == (flt1 || flt2), flt1 ? "R4 fault flag" : "R5 fault flag", 64'(flt_seen), 64'(flt1 || flt2));
        check(pa_seen == exp_pa, (flt1 || flt2) ? "R7 fault pa" : "R6 pa", 64'(pa_seen), 64'(exp_pa));
        check((acc_total - n0) == (flt1 ? 1 : 2), "R4/R9 read count", 64'(acc_total - n0), 64'(flt1 ? 1 : 2));
        if (flt1) check(acc_last == a1, "R2 l1 addr", 64'(acc_last), 64'(a1));
        else begin
            check(acc_prev == a1, "R2 l1 addr", 64'(acc_prev), 64'(a1));
            check(acc_last == a2, "R3 l2 addr", 64'(acc_last), 64'(a2));
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(rsp_valid && rsp_pa == pa_seen && rsp_fault == flt_seen, "R8 hold",
                  64'(rsp_pa), 64'(pa_seen));
        end
        rsp_ready = 1'b1;
        if (collide) begin
            req_valid = 1'b1;
            check(req_ready == 1'b0, "R1 no accept while rsp", 64'(req_ready), 64'd0);
        end
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid == 1'b0, "R1 rsp taken", 64'(rsp_valid), 64'd0);
        if (collide) begin
            check(req_ready == 1'b1, "R1 ready after take", 64'(req_ready), 64'd1);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R10 rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_valid == 1'b0, "R10 mem_valid", 64'(mem_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 8; j++) begin
                walk(i, j * 131 % 1024, (i * 37 + j * 501) % 4096, (i + j) % 3, (j % 2) == 1);
            end
        end
        walk(1023, 1023, 4095, 2, 1'b1);
        walk(1023, 0, 0, 0, 1'b0);
        walk(0, 1023, 1, 1, 1'b1);
        walk(2, 5, 7, 1, 1'b0);
        walk(1, 2, 4095, 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule